// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block watches an active-low composite sync stream together with a one-cycle line-start strobe from the horizontal sync extractor. It recognises the broad low pulses of the vertical interval, drives an active-low vertical sync of a length that depends on the line standard, and reports whether the field now starting is field 1 (odd lines) or field 2 (even lines).

The line standard, 525-line or 625-line, is detected without software help by counting line strobes from one vertical interval to the next vertical interval of the same phase. The phase is whether the vertical interval starts near a line start or about half a line later. The two standards put the half line at opposite field boundaries, so the field decision uses both the phase and the standard. All state changes on the falling clock edge. The reset is asynchronous and active low and is released synchronously inside the block.

Top module: `vsync_field_det`

## Requirements
- R1: While reset is asserted, and for two falling clock edges after it is released, the outputs read `vsync_n`=1, `field_odd`=1 and `std625`=0 (0 means 525-line, 1 means 625-line).
- R2: A serration pulse is a run of more than LINE_CLKS/2 consecutive low samples of `csync_n`. `vsync_n` goes low at the falling edge that takes the (LINE_CLKS/2+1)-th low sample. A run of exactly LINE_CLKS/2 samples or fewer never lowers `vsync_n`.
- R3: Once low, `vsync_n` stays low for exactly VS525_CLKS cycles when the standard in force for that interval is 525-line, and for VS625_CLKS cycles when it is 625-line.
- R4: A serration pulse starts a vertical interval only after at least QUIET_LINES line strobes have been seen while `vsync_n` was high, counted since its last rising edge or since reset. Any other serration pulse changes no output.
- R5: A serration pulse that ends while `vsync_n` is already low neither restarts nor lengthens the vertical sync.
- R6: The phase of a pulse is the number of falling edges between the last `line_stb` sample and the pulse's first low sample, with 0 when both fall on the same edge. A phase below LINE_CLKS/4 is line-aligned. A phase of LINE_CLKS/4 or more is half-line offset.
- R7: When a vertical interval starts, `std625` becomes 1 if more than STD_SPLIT line strobes were sampled strictly between the previous start of the same phase and this one, and 0 otherwise. The first interval of each phase after reset leaves `std625` unchanged.
- R8: At each vertical interval start, `field_odd` becomes 1 for a line-aligned interval under 525-line or a half-line-offset interval under 625-line, and 0 for the other two cases. The standard used is the one decided at that same start.
- R9: `field_odd` and `std625` change only on the cycle in which `vsync_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Composite sync, active low, synchronous to clk |
| line_stb | input | 1 | One-cycle pulse at each detected line start |
| vsync_n | output | 1 | Vertical sync, active low |
| field_odd | output | 1 | 1 for field 1 (odd), 0 for field 2 (even) |
| std625 | output | 1 | Detected standard: 0 = 525-line, 1 = 625-line |

## Verification
The hardest state to reach is a change of standard, in either direction. The line count is compared only between intervals of the same phase, so a new standard takes effect only after a full frame of the new length. During that frame the offset intervals can measure a mixed count close to the threshold. The stimulus therefore runs whole interlaced frames of 525 lines, then 625 lines, then 525 lines again, with the field phase alternating. It uses a short line period, so frames stay affordable while every line still gets its strobe. Single-line disturbances are placed inside those frames to reach the quiet-window, overlap and phase-boundary cases.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  // Position of a vertical interval relative to the line start
  typedef enum logic {
    PH_LINE = 1'b0,  // starts near the line strobe
    PH_HALF = 1'b1   // starts about half a line later
  } phase_e;
endpackage

// File: rtl/vfd_rst_sync.sv
module vfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/vfd_pulse_meas.sv
module vfd_pulse_meas
  import vfd_pkg::*;
#(
  parameter int LINE_CLKS = 858
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   csync_n,
  input  logic   line_stb,
  output logic   serr_hit,
  output phase_e serr_phase
);
  localparam int HALF = LINE_CLKS / 2;
  localparam int QTR  = LINE_CLKS / 4;
  localparam int PW   = $clog2(LINE_CLKS + 1) + 1;
  localparam logic [PW-1:0] PMAX = '1;

  logic [PW-1:0] pos_q, pos_d;
  logic [PW-1:0] low_q, low_d;
  phase_e        ph_q, ph_d;

  always_comb begin
    pos_d = line_stb ? '0 : ((pos_q == PMAX) ? pos_q : pos_q + PW'(1));
    low_d = csync_n  ? '0 : ((low_q == PMAX) ? low_q : low_q + PW'(1));
    ph_d  = ph_q;
    if (low_d == PW'(1))
      ph_d = (pos_d >= PW'(QTR)) ? PH_HALF : PH_LINE;
  end

  // First sample at which the low run exceeds half a line
  assign serr_hit   = (low_d == PW'(HALF + 1));
  assign serr_phase = ph_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      low_q <= '0;
      ph_q  <= PH_LINE;
    end else begin
      pos_q <= pos_d;
      low_q <= low_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/vfd_std_track.sv
module vfd_std_track
  import vfd_pkg::*;
#(
  parameter int STD_SPLIT = 575
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   line_stb,
  input  logic   start,
  input  phase_e start_phase,
  output logic   std_next,
  output logic   std625
);
  localparam int CW = $clog2(STD_SPLIT + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic                 sel;
  logic [1:0][CW-1:0]   cnt_all;
  logic [1:0]           vld_all;
  logic                 std_q;

  assign sel = start_phase;

  for (genvar p = 0; p < 2; p++) begin : g_phase
    logic [CW-1:0] cnt_q, cnt_d;
    logic          vld_q, vld_d, mine;

    always_comb begin
      mine  = start && (sel == 1'(p));
      vld_d = vld_q | mine;
      if (mine)                           cnt_d = '0;
      else if (line_stb && cnt_q != CMAX) cnt_d = cnt_q + CW'(1);
      else                                cnt_d = cnt_q;
    end

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        vld_q <= 1'b0;
      end else begin
        cnt_q <= cnt_d;
        vld_q <= vld_d;
      end
    end

    assign cnt_all[p] = cnt_q;
    assign vld_all[p] = vld_q;
  end

  always_comb begin
    std_next = std_q;
    if (start && vld_all[sel])
      std_next = (cnt_all[sel] > CW'(STD_SPLIT));
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) std_q <= 1'b0;
    else        std_q <= std_next;
  end

  assign std625 = std_q;
endmodule

// File: rtl/vsync_field_det.sv
module vsync_field_det
  import vfd_pkg::*;
#(
  parameter int LINE_CLKS   = 858,
  parameter int VS525_CLKS  = 2565,
  parameter int VS625_CLKS  = 1728,
  parameter int QUIET_LINES = 10,
  parameter int STD_SPLIT   = 575
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  input  logic line_stb,
  output logic vsync_n,
  output logic field_odd,
  output logic std625
);
  localparam int VMAX = (VS525_CLKS > VS625_CLKS) ? VS525_CLKS : VS625_CLKS;
  localparam int VW   = $clog2(VMAX + 1);
  localparam int QW   = $clog2(QUIET_LINES + 1);

  logic           rst_s_n;
  logic           serr_hit;
  phase_e         serr_phase;
  logic           start;
  logic           std_next;
  logic [QW-1:0]  quiet_q, quiet_d;
  logic           vs_q, vs_d;
  logic [VW-1:0]  vcnt_q, vcnt_d;
  logic           fld_q, fld_d;

  vfd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  vfd_pulse_meas #(.LINE_CLKS(LINE_CLKS)) u_meas (
    .clk(clk), .rst_n(rst_s_n), .csync_n(csync_n), .line_stb(line_stb),
    .serr_hit(serr_hit), .serr_phase(serr_phase)
  );

  vfd_std_track #(.STD_SPLIT(STD_SPLIT)) u_std (
    .clk(clk), .rst_n(rst_s_n), .line_stb(line_stb), .start(start),
    .start_phase(serr_phase), .std_next(std_next), .std625(std625)
  );

  always_comb begin
    start   = serr_hit && vs_q && (quiet_q >= QW'(QUIET_LINES));
    quiet_d = quiet_q;
    if (!vs_q)
      quiet_d = '0;
    else if (line_stb && quiet_q < QW'(QUIET_LINES))
      quiet_d = quiet_q + QW'(1);

    vs_d   = vs_q;
    vcnt_d = vcnt_q;
    fld_d  = fld_q;
    if (start) begin
      vs_d   = 1'b0;
      vcnt_d = std_next ? VW'(VS625_CLKS - 1) : VW'(VS525_CLKS - 1);
      fld_d  = ((serr_phase == PH_HALF) == std_next);
    end else if (!vs_q) begin
      if (vcnt_q == '0) vs_d = 1'b1;
      else              vcnt_d = vcnt_q - VW'(1);
    end
  end

  always_ff @(negedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      quiet_q <= '0;
      vs_q    <= 1'b1;
      vcnt_q  <= '0;
      fld_q   <= 1'b1;
    end else begin
      quiet_q <= quiet_d;
      vs_q    <= vs_d;
      vcnt_q  <= vcnt_d;
      fld_q   <= fld_d;
    end
  end

  assign vsync_n   = vs_q;
  assign field_odd = fld_q;
endmodule

// File: rtl/vfd_chk.sv
module vfd_chk #(
  parameter int QUIET_LINES = 10,
  parameter int VS525_CLKS  = 2565,
  parameter int VS625_CLKS  = 1728
) (
  input logic clk,
  input logic rst_n,
  input logic csync_n,
  input logic line_stb,
  input logic vsync_n,
  input logic field_odd,
  input logic std625
);
  logic [31:0] low_run;
  logic [31:0] hi_lines;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      hi_lines <= '0;
    end else begin
      low_run <= vsync_n ? '0 : low_run + 32'd1;
      if (!vsync_n)
        hi_lines <= '0;
      else if (line_stb && hi_lines < 32'(QUIET_LINES))
        hi_lines <= hi_lines + 32'd1;
    end
  end

  a_r3_low_width: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> low_run == (std625 ? 32'(VS625_CLKS) : 32'(VS525_CLKS)));

  a_r4_quiet_before_fall: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> $past(hi_lines) >= 32'(QUIET_LINES));

  a_r2_fall_needs_low: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> !$past(csync_n));

  a_r9_field_hold: assert property (@(negedge clk) disable iff (!rst_n)
    !$fell(vsync_n) |-> $stable(field_odd));

  a_r9_std_hold: assert property (@(negedge clk) disable iff (!rst_n)
    !$fell(vsync_n) |-> $stable(std625));
endmodule

bind vsync_field_det vfd_chk #(
  .QUIET_LINES(QUIET_LINES), .VS525_CLKS(VS525_CLKS), .VS625_CLKS(VS625_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .line_stb(line_stb),
  .vsync_n(vsync_n), .field_odd(field_odd), .std625(std625)
);

// File: tb/vsync_field_det_tb.sv
module vsync_field_det_tb;
  localparam int LINE  = 16;
  localparam int VSA   = 40;
  localparam int VSB   = 26;
  localparam int QL    = 10;
  localparam int SPLIT = 575;
  localparam int HALF  = LINE / 2;
  localparam int QTR   = LINE / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync_n = 1'b1;
  logic line_stb = 1'b0;
  logic vsync_n, field_odd, std625;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  vsync_field_det #(
    .LINE_CLKS(LINE), .VS525_CLKS(VSA), .VS625_CLKS(VSB),
    .QUIET_LINES(QL), .STD_SPLIT(SPLIT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .line_stb(line_stb),
    .vsync_n(vsync_n), .field_odd(field_odd), .std625(std625)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Behavioural reference, advanced on every active (falling) edge
  int m_rel, m_pos, m_low, m_quiet, m_vcnt;
  int m_cnt[2];
  bit m_val[2];
  bit m_off, m_vs, m_field, m_std;

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_pos = 0; m_low = 0; m_quiet = 0; m_vcnt = 0;
      m_cnt[0] = 0; m_cnt[1] = 0; m_val[0] = 0; m_val[1] = 0;
      m_off = 0; m_vs = 1; m_field = 1; m_std = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      int  pos_n, low_n, ph;
      bit  hit, st, std_n;
      pos_n = line_stb ? 0 : m_pos + 1;
      low_n = csync_n ? 0 : m_low + 1;
      ph    = int'(m_off);
      if (low_n == 1) m_off = (pos_n >= QTR);
      hit   = (low_n == HALF + 1);
      st    = hit && m_vs && (m_quiet >= QL);
      std_n = m_std;
      if (st) begin
        if (m_val[ph]) std_n = (m_cnt[ph] > SPLIT);
        m_val[ph] = 1;
      end
      for (int p = 0; p < 2; p++) begin
        if (st && p == ph) m_cnt[p] = 0;
        else if (line_stb) m_cnt[p]++;
      end
      if (!m_vs) m_quiet = 0;
      else if (line_stb && m_quiet < QL) m_quiet++;
      if (st) begin
        m_vs    = 0;
        m_vcnt  = (std_n ? VSB : VSA) - 1;
        m_field = ((ph == 1) == std_n);
      end else if (!m_vs) begin
        if (m_vcnt == 0) m_vs = 1;
        else m_vcnt--;
      end
      m_std = std_n;
      m_pos = pos_n;
      m_low = low_n;
    end
  end

  // Per-cycle comparison and vsync observation, away from the active edge
  int  run_len = 0;
  int  last_len = 0;
  int  n_falls = 0;
  bit  prev_vs = 1'b1;

  always @(posedge clk) begin
    if (rst_n && !done) begin
      check(vsync_n === m_vs, "R2 R3 R4 R5 vsync_n", int'(vsync_n), int'(m_vs));
      check(field_odd === m_field, "R6 R8 field_odd", int'(field_odd), int'(m_field));
      check(std625 === m_std, "R7 std625", int'(std625), int'(m_std));
      if (prev_vs && !vsync_n) n_falls++;
      if (!vsync_n) run_len++;
      else if (run_len > 0) begin
        last_len = run_len;
        run_len  = 0;
      end
      prev_vs = vsync_n;
    end
  end

  // Stimulus: one line of LINE cycles, with an optional extra low pulse
  int lowleft = 0;

  task automatic one_line(input int xpos, input int xw);
    for (int c = 0; c < LINE; c++) begin
      @(posedge clk);
      line_stb = (c == 0);
      if (c == 0 && lowleft < 2) lowleft = 2;
      if (c == xpos && xw > lowleft) lowleft = xw;
      csync_n = !(lowleft > 0);
      if (lowleft > 0) lowleft--;
    end
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) one_line(-1, 0);
  endtask

  // A field: vertical pulse in line 0 (aligned or half-line), extra pulse at line xl
  task automatic field(input bit half, input int n, input int xl);
    one_line(half ? HALF : 0, 12);
    for (int i = 1; i < n; i++) begin
      if (i == xl) one_line(0, 12);
      else one_line(-1, 0);
    end
  endtask

  initial begin
    int falls0;
    repeat (5) @(posedge clk);
    check(vsync_n === 1'b1, "R1 vsync_n in reset", int'(vsync_n), 1);
    check(field_odd === 1'b1, "R1 field_odd in reset", int'(field_odd), 1);
    check(std625 === 1'b0, "R1 std625 in reset", int'(std625), 0);
    rst_n = 1'b1;
    @(posedge clk);
    check(vsync_n === 1'b1 && field_odd === 1'b1 && std625 === 1'b0,
          "R1 held after release", int'({vsync_n, field_odd, std625}), 6);
    lines(12);

    // 525-line frames
    field(0, 262, -1);
    check(field_odd === 1'b1, "R8 aligned 525 first", int'(field_odd), 1);
    check(std625 === 1'b0, "R7 first interval keeps default", int'(std625), 0);
    field(1, 263, -1);
    check(field_odd === 1'b0, "R8 offset 525", int'(field_odd), 0);
    field(0, 262, -1);
    check(std625 === 1'b0, "R7 525 count", int'(std625), 0);
    check(last_len == VSA, "R3 525 length", last_len, VSA);
    field(1, 263, -1);

    // 625-line frames
    field(0, 312, -1);
    field(1, 313, -1);
    field(0, 312, -1);
    check(std625 === 1'b1, "R7 625 detect", int'(std625), 1);
    check(field_odd === 1'b0, "R8 aligned 625", int'(field_odd), 0);
    check(last_len == VSB, "R3 625 length", last_len, VSB);
    field(1, 313, -1);
    check(field_odd === 1'b1, "R8 offset 625", int'(field_odd), 1);
    field(0, 312, -1);
    field(1, 313, -1);

    // Back to 525 lines, with an early pulse inside the quiet window
    field(0, 262, 6);
    check(field_odd === 1'b0 && std625 === 1'b1, "R4 early pulse ignored",
          int'({field_odd, std625}), 1);
    field(1, 263, -1);
    field(0, 262, 1);
    check(last_len == VSA, "R5 overlap does not extend", last_len, VSA);
    check(std625 === 1'b0, "R7 return to 525", int'(std625), 0);
    check(field_odd === 1'b1, "R8 aligned 525 again", int'(field_odd), 1);
    field(1, 263, -1);

    // Pulse-width and phase boundaries
    lines(12);
    falls0 = n_falls;
    one_line(0, 8);
    lines(1);
    check(n_falls == falls0, "R2 half-line pulse ignored", n_falls, falls0);
    check(field_odd === 1'b0, "R2 field unchanged", int'(field_odd), 0);
    lines(1);
    one_line(3, 12);
    check(n_falls == falls0 + 1, "R2 long pulse detected", n_falls, falls0 + 1);
    check(field_odd === 1'b1, "R6 phase just under quarter is aligned", int'(field_odd), 1);
    lines(14);
    one_line(4, 12);
    check(field_odd === 1'b0, "R6 phase at quarter is offset", int'(field_odd), 0);
    lines(14);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end
endmodule